// File: doc/BRIEF.md
# SIMD Fractional Saturating Multiplier

This block multiplies two 64-bit packed operands lane by lane. Each lane holds a signed fixed-point fraction. A mode bit, sampled together with the operands, picks one of two layouts. One layout is eight 8-bit Q7 lanes. The other is four 16-bit Q15 lanes. Each lane forms the full double-width signed product and shifts it right arithmetically by the lane's fraction width, so the result is back in the lane's own Q format. The result lands in the same bit positions the inputs came from. Because the high part of a fractional product is kept, only one input pair can leave the range: the most negative value times itself. That lane is clamped to the largest positive value and an overflow is reported.

The block sits in an execution pipeline. An operation enters on a valid strobe and its result comes out, with its own valid, two clock edges later. One new operation may enter every cycle. A per-operation overflow output flags the saturating results. A sticky overflow bit gathers them until a synchronous clear input drops it, standing in for the status register of the surrounding core.

Top module: `simd_qmul`

## Requirements
- R1: With mode 1 (16-bit lanes), lane i of the result, bits [16i+15:16i], equals bits [15:0] of the signed product of the matching operand lanes shifted right arithmetically by 15. This holds whenever the two inputs are not both 0x8000.
- R2: With mode 0 (8-bit lanes), lane i of the result, bits [8i+7:8i], equals bits [7:0] of the signed product of the matching operand lanes shifted right arithmetically by 7. This holds whenever the two inputs are not both 0x80.
- R3: A 16-bit lane whose two inputs are both 0x8000 yields 0x7FFF and raises `out_ovf`. A lane with only one 0x8000 input does not saturate.
- R4: An 8-bit lane whose two inputs are both 0x80 yields 0x7F and raises `out_ovf`. For example, 0x80 times 0x81 gives 0x7F without overflow.
- R5: `in_mode` is sampled with the operands while `in_valid` is high. The same operands give results shaped by the mode of their own operation, not by the mode of a neighbouring operation.
- R6: An operation accepted at a rising edge with `in_valid` high shows `out_valid` high for exactly one cycle, after the second rising edge. A new operation may be accepted on every cycle.
- R7: `out_ovf` is high exactly when `out_valid` is high and at least one lane of that result saturated. It is low at all other times.
- R8: `ovf_sticky` goes high in the same cycle as any `out_ovf` and stays high until an edge with `ovf_clear` high. If a saturating result arrives at the same edge as a clear, the flag stays high.
- R9: While `rst_n` is low at a rising edge, `out_valid`, `out_result`, `out_ovf` and `ovf_sticky` become zero.
- R10: Operands presented with `in_valid` low are ignored. `out_valid` stays low for that slot and `out_result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe; operands and mode are sampled when high |
| in_mode | input | 1 | Lane layout: 0 = eight Q7 lanes, 1 = four Q15 lanes |
| in_a | input | DATA_W | First packed operand |
| in_b | input | DATA_W | Second packed operand |
| ovf_clear | input | 1 | Synchronous clear of the sticky overflow flag |
| out_valid | output | 1 | Result strobe, one cycle per accepted operation |
| out_result | output | DATA_W | Packed result; holds its last value between operations |
| out_ovf | output | 1 | At least one lane of the current result saturated |
| ovf_sticky | output | 1 | Accumulated overflow since the last clear |

## Verification
The assertions watch, on every cycle, the two-edge valid latency, the holding of the result across idle slots, the tie between `out_ovf` and `out_valid`, the set, hold and clear rules of the sticky flag, and the clamp of lane 0 when both inputs are the minimum value in either mode. The lane arithmetic in all other positions and value ranges can only be shown by the bench. It compares every result against a lane-by-lane reference across random streams that mix both modes and idle slots. Directed cases cover the minimum-times-minimum clamp in every lane, minimum times a near-minimum value, negative products that round toward minus infinity, and one operand pair whose result differs by mode.

// File: rtl/simd_qmul_pkg.sv
// Package: shared definitions for the packed fractional multiplier.
// Assumes the datapath width is a multiple of the widest lane (16 bits).
package simd_qmul_pkg;

    // Lane layout selected per operation
    typedef enum logic {
        LANES_Q7  = 1'b0,
        LANES_Q15 = 1'b1
    } lane_mode_e;

    localparam int NARROW_W = 8;
    localparam int WIDE_W   = 16;

endpackage

// File: rtl/qmul_lane.sv
// Module: qmul_lane
// One signed fractional lane. It forms the full product of two W-bit
// fractions and keeps bits [2W-2:W-1], i.e. the product shifted right
// arithmetically by W-1 and truncated to W bits. The single input pair that
// cannot be represented (minimum times minimum) is clamped to the maximum
// positive value and reported on sat_o.
// Assumes W >= 2. Purely combinational.
module qmul_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o,
    output logic         sat_o
);

    localparam int          PW    = 2 * W;
    localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};

    logic signed [PW-1:0] prod;
    logic                 both_min;
    logic                 unused_prod_bits;

    // Full-width signed product of the two lane inputs
    always_comb begin
        prod = $signed({{W{a_i[W-1]}}, a_i}) * $signed({{W{b_i[W-1]}}, b_i});
    end

    // Detect the only unrepresentable case
    always_comb begin
        both_min = (a_i == MIN_V) && (b_i == MIN_V);
    end

    // Rescale to the lane's Q format, clamping the lone overflow case
    always_comb begin
        sat_o = both_min;
        if (both_min) begin
            res_o = MAX_V;
        end else begin
            res_o = prod[PW-2:W-1];
        end
    end

    assign unused_prod_bits = ^{prod[PW-1], prod[W-2:0]};

endmodule

// File: rtl/qmul_lane_bank.sv
// Module: qmul_lane_bank
// Splits two packed operands into DATA_W/LANE_W lanes of equal width. All
// lanes are multiplied in parallel and the results are packed back at the
// same bit positions. The per-lane saturation flags are also returned,
// together with their OR.
// Assumes DATA_W is a multiple of LANE_W. Purely combinational.
module qmul_lane_bank #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0]           a_i,
    input  logic [DATA_W-1:0]           b_i,
    output logic [DATA_W-1:0]           res_o,
    output logic [DATA_W/LANE_W-1:0]    lane_sat_o,
    output logic                        any_sat_o
);

    localparam int N_LANES = DATA_W / LANE_W;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        qmul_lane #(
            .W (LANE_W)
        ) u_lane (
            .a_i   (a_i[g*LANE_W +: LANE_W]),
            .b_i   (b_i[g*LANE_W +: LANE_W]),
            .res_o (res_o[g*LANE_W +: LANE_W]),
            .sat_o (lane_sat_o[g])
        );
    end

    // Reduce the per-lane saturation flags to one overflow bit
    always_comb begin
        any_sat_o = |lane_sat_o;
    end

endmodule

// File: rtl/qmul_sticky.sv
// Module: qmul_sticky
// Sticky overflow flag. A set request always wins over a clear that arrives
// at the same edge, so no overflow event is lost.
// Assumes synchronous active-low reset.
module qmul_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    // Accumulate overflow events until cleared
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end

endmodule

// File: rtl/simd_qmul.sv
// Module: simd_qmul (top)
// Packed fractional multiplier with two register stages. Stage 1 captures
// the operands and mode on in_valid. Both lane banks work on the captured
// operands and the mode picks one of their results. Stage 2 registers the
// picked result, the valid bit and the overflow, and feeds the sticky flag.
// Assumes DATA_W is a multiple of 16. Synchronous active-low reset.
module simd_qmul
    import simd_qmul_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_mode,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic              ovf_clear,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_ovf,
    output logic              ovf_sticky
);

    localparam int N_NARROW = DATA_W / NARROW_W;
    localparam int N_WIDE   = DATA_W / WIDE_W;

    logic              s1_valid;
    lane_mode_e        s1_mode;
    logic [DATA_W-1:0] s1_a;
    logic [DATA_W-1:0] s1_b;

    logic [DATA_W-1:0]   narrow_res;
    logic [N_NARROW-1:0] narrow_lane_sat;
    logic                narrow_sat;
    logic [DATA_W-1:0]   wide_res;
    logic [N_WIDE-1:0]   wide_lane_sat;
    logic                wide_sat;

    logic [DATA_W-1:0] pick_res;
    logic              pick_sat;
    logic              ovf_event;

    // Stage 1: capture operands and mode of an accepted operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_mode  <= LANES_Q7;
            s1_a     <= '0;
            s1_b     <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_mode <= lane_mode_e'(in_mode);
                s1_a    <= in_a;
                s1_b    <= in_b;
            end
        end
    end

    qmul_lane_bank #(
        .DATA_W (DATA_W),
        .LANE_W (NARROW_W)
    ) u_bank_narrow (
        .a_i        (s1_a),
        .b_i        (s1_b),
        .res_o      (narrow_res),
        .lane_sat_o (narrow_lane_sat),
        .any_sat_o  (narrow_sat)
    );

    qmul_lane_bank #(
        .DATA_W (DATA_W),
        .LANE_W (WIDE_W)
    ) u_bank_wide (
        .a_i        (s1_a),
        .b_i        (s1_b),
        .res_o      (wide_res),
        .lane_sat_o (wide_lane_sat),
        .any_sat_o  (wide_sat)
    );

    // Pick the bank that matches the captured lane layout
    always_comb begin
        if (s1_mode == LANES_Q15) begin
            pick_res = wide_res;
            pick_sat = wide_sat;
        end else begin
            pick_res = narrow_res;
            pick_sat = narrow_sat;
        end
    end

    // Overflow only counts for a live operation
    always_comb begin
        ovf_event = s1_valid & pick_sat;
    end

    // Stage 2: present the result, its strobe and its overflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_ovf    <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            out_ovf   <= ovf_event;
            if (s1_valid) begin
                out_result <= pick_res;
            end
        end
    end

    qmul_sticky u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ovf_event),
        .clr_i  (ovf_clear),
        .flag_o (ovf_sticky)
    );

endmodule

// File: rtl/simd_qmul_chk.sv
// Module: simd_qmul_chk
// Property checker bound to every simd_qmul instance. It observes only the
// top-level ports and checks timing, flag and lane-0 clamp rules.
// Assumes the same synchronous active-low reset as the design.
module simd_qmul_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_mode,
    input logic [DATA_W-1:0] in_a,
    input logic [DATA_W-1:0] in_b,
    input logic              ovf_clear,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic              out_ovf,
    input logic              ovf_sticky
);

    logic unused_hi;
    assign unused_hi = ^{in_a[DATA_W-1:16], in_b[DATA_W-1:16], out_result[DATA_W-1:16]};

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid); // R6

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid); // R10

    AST_IDLE_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 $stable(out_result)); // R10

    AST_OVF_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf |-> out_valid); // R7

    AST_STICKY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf |-> ovf_sticky); // R8

    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_sticky && !ovf_clear) |=> ovf_sticky); // R8

    AST_STICKY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_clear |=> (ovf_sticky == out_ovf)); // R8

    AST_Q15_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode && in_a[15:0] == 16'h8000 && in_b[15:0] == 16'h8000)
        |=> ##1 (out_result[15:0] == 16'h7FFF && out_ovf)); // R3

    AST_Q7_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_mode && in_a[7:0] == 8'h80 && in_b[7:0] == 8'h80)
        |=> ##1 (out_result[7:0] == 8'h7F && out_ovf)); // R4

endmodule

bind simd_qmul simd_qmul_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/simd_qmul_test.sv
`timescale 1ns/1ps
module simd_qmul_test;

    localparam int    DATA_W      = 64;
    localparam int    N_RANDOM    = 3000;
    localparam time   WATCHDOG_NS = 200000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_mode = 1'b0;
    logic [DATA_W-1:0] in_a = '0;
    logic [DATA_W-1:0] in_b = '0;
    logic              ovf_clear = 1'b0;
    logic              out_valid;
    logic [DATA_W-1:0] out_result;
    logic              out_ovf;
    logic              ovf_sticky;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    // Bench model of the pipeline
    logic              m_s1_v = 1'b0;
    logic              m_s1_mode = 1'b0;
    logic [DATA_W-1:0] m_s1_a = '0;
    logic [DATA_W-1:0] m_s1_b = '0;
    string             m_s1_tag = "";
    logic              e_valid = 1'b0;
    logic [DATA_W-1:0] e_res = '0;
    logic              e_ovf = 1'b0;
    logic              e_sticky = 1'b0;
    string             e_res_tag = "R9";
    string             e_ovf_tag = "R9";

    always #2 clk = ~clk;

    simd_qmul #(.DATA_W(DATA_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_mode    (in_mode),
        .in_a       (in_a),
        .in_b       (in_b),
        .ovf_clear  (ovf_clear),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_ovf    (out_ovf),
        .ovf_sticky (ovf_sticky)
    );

    // Reference: returns {overflow, packed result} from the lane rules
    function automatic logic [DATA_W:0] ref_mul(input logic mode,
                                                input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
        logic [DATA_W-1:0] r = '0;
        logic              ov = 1'b0;
        int                lw = mode ? 16 : 8;
        for (int i = 0; i < DATA_W / lw; i++) begin
            longint x, y, p;
            longint lim = -(longint'(1) << (lw - 1));
            if (mode) begin
                x = longint'($signed(a[16*i +: 16]));
                y = longint'($signed(b[16*i +: 16]));
            end else begin
                x = longint'($signed(a[8*i +: 8]));
                y = longint'($signed(b[8*i +: 8]));
            end
            if (x == lim && y == lim) begin
                ov = 1'b1;
                p  = -lim - 1;
            end else begin
                p = (x * y) >>> (lw - 1);
            end
            if (mode) r[16*i +: 16] = p[15:0];
            else      r[8*i +: 8]   = p[7:0];
        end
        return {ov, r};
    endfunction

    task automatic check(input string tag, input logic [DATA_W-1:0] got,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    // One cycle: check outputs at negedge, drive new inputs, advance model
    task automatic step(input logic v, input logic m, input logic [DATA_W-1:0] a,
                        input logic [DATA_W-1:0] b, input logic clr, input string tag);
        logic [DATA_W:0] r;
        check("R6 out_valid", DATA_W'(out_valid), DATA_W'(e_valid));
        if (e_valid) begin
            check(e_res_tag, out_result, e_res);
            check(e_ovf_tag, DATA_W'(out_ovf), DATA_W'(e_ovf));
        end else begin
            check("R10 result held", out_result, e_res);
            check("R7 idle ovf", DATA_W'(out_ovf), '0);
        end
        check("R8 sticky", DATA_W'(ovf_sticky), DATA_W'(e_sticky));

        in_valid  = v;
        in_mode   = m;
        in_a      = a;
        in_b      = b;
        ovf_clear = clr;

        e_valid = m_s1_v;
        if (m_s1_v) begin
            r     = ref_mul(m_s1_mode, m_s1_a, m_s1_b);
            e_res = r[DATA_W-1:0];
            e_ovf = r[DATA_W];
            e_ovf_tag = r[DATA_W] ? (m_s1_mode ? "R3 ovf" : "R4 ovf") : "R7 ovf";
            if (m_s1_tag != "")  e_res_tag = m_s1_tag;
            else if (r[DATA_W])  e_res_tag = m_s1_mode ? "R3 clamp" : "R4 clamp";
            else                 e_res_tag = m_s1_mode ? "R1 q15" : "R2 q7";
        end else begin
            e_ovf = 1'b0;
        end
        e_sticky = (m_s1_v & e_ovf) | (e_sticky & ~clr);

        m_s1_v = v;
        if (v) begin
            m_s1_mode = m;
            m_s1_a    = a;
            m_s1_b    = b;
            m_s1_tag  = tag;
        end
        @(negedge clk);
    endtask

    // Force some lanes to the minimum value in both operands
    function automatic logic [2*DATA_W-1:0] inject(input logic m,
                                                   input logic [DATA_W-1:0] a,
                                                   input logic [DATA_W-1:0] b);
        int lw = m ? 16 : 8;
        for (int i = 0; i < DATA_W / lw; i++) begin
            if ($urandom % 3 == 0) begin
                if (m) begin
                    a[16*i +: 16] = 16'h8000;
                    b[16*i +: 16] = ($urandom % 4 == 0) ? 16'h8001 : 16'h8000;
                end else begin
                    a[8*i +: 8] = 8'h80;
                    b[8*i +: 8] = ($urandom % 4 == 0) ? 8'h81 : 8'h80;
                end
            end
        end
        return {a, b};
    endfunction

    initial begin
        #(WATCHDOG_NS);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'h1F2E3D4C);

        // R9: outputs cleared by reset
        in_valid = 1'b1;
        in_a = '1;
        in_b = '1;
        repeat (3) @(negedge clk);
        check("R9 reset out_valid", DATA_W'(out_valid), '0);
        check("R9 reset out_result", out_result, '0);
        check("R9 reset out_ovf", DATA_W'(out_ovf), '0);
        check("R9 reset sticky", DATA_W'(ovf_sticky), '0);
        in_valid = 1'b0;
        in_a = '0;
        in_b = '0;
        rst_n = 1'b1;
        @(negedge clk);

        // R3: every Q15 lane minimum times minimum
        step(1, 1, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 0, "R3 all lanes");
        // R3: one lane saturates, others give 0x2000 and 0x8001
        step(1, 1, 64'h4000_8000_8000_4000, 64'h4000_7FFF_8000_4000, 0, "R3 mixed lanes");
        // R1: single minimum input does not saturate
        step(1, 1, 64'h8000_FFFF_0001_7FFF, 64'h8001_0001_FFFF_7FFF, 0, "R1 corners");
        // R4: every Q7 lane minimum times minimum
        step(1, 0, 64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080, 0, "R4 all lanes");
        // R4: 0x80 times 0x81 gives 0x7F without overflow
        step(1, 0, 64'h8080_8080_8080_8080, 64'h8181_8181_8181_8181, 0, "R4 near min");
        // R2: negative products round toward minus infinity
        step(1, 0, 64'hFF01_7F40_C0FF_0102, 64'h0101_7F40_40FF_FE02, 0, "R2 signs");
        // R5: same operands, both modes, back to back
        step(1, 1, 64'h0101_0101_0101_0101, 64'h0101_0101_0101_0101, 0, "R5 mode q15");
        step(1, 0, 64'h0101_0101_0101_0101, 64'h0101_0101_0101_0101, 0, "R5 mode q7");
        // R10: operands with valid low are ignored
        step(0, 1, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 0, "");
        step(0, 0, '1, '1, 0, "");
        step(0, 0, '0, '0, 0, "");
        // R8: clear with no pending overflow drops the flag
        step(0, 0, '0, '0, 1, "");
        step(0, 0, '0, '0, 0, "");
        // R8: overflow arriving with a clear keeps the flag set
        step(1, 0, 64'h0000_0000_0000_0080, 64'h0000_0000_0000_0080, 0, "R8 set");
        step(0, 0, '0, '0, 1, "");
        step(0, 0, '0, '0, 0, "");
        step(0, 0, '0, '0, 0, "");

        // Random streams over both modes, idle slots and clears
        for (int n = 0; n < N_RANDOM; n++) begin
            logic              v = ($urandom % 4) != 0;
            logic              m = $urandom % 2;
            logic [DATA_W-1:0] a = {$urandom, $urandom};
            logic [DATA_W-1:0] b = {$urandom, $urandom};
            logic              c = ($urandom % 8) == 0;
            if ($urandom % 4 == 0) {a, b} = inject(m, a, b);
            step(v, m, a, b, c, "");
        end
        repeat (3) step(0, 0, '0, '0, 0, "");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule